// File: doc/BRIEF.md
# Serial Four-Bit Pattern Detector

This block watches a serial bit stream and raises a one-cycle detect pulse each time the last four accepted bits, oldest first, are 0, 1, 0, 0. A bit counts only when the bit-valid strobe is high. Each accepted bit enters the top stage of a four-stage shift register, and the older bits move one stage down. The register contents are the Moore state of the detector, and a wide AND over those contents produces the detect output. The four stored bits are also brought out so that a debug path can read them.

Read the register as a binary number with the top stage as the most significant bit. The match value is then 0010. The reset value is 1100, which is the start state of the minimal machine for this pattern. No prefix of the pattern is held in the register after reset, so the detector needs four real bits before it can flag anything. A register cleared to all zeros would instead flag after only 1, 0, 0. Occurrences may overlap: after a detect, the bits 1, 0, 0 finish a second match.

Top module: `serial_pattern_detect`

## Requirements
- R1: While reset is high at a clock edge, the state output becomes 1100 (binary, top stage first) and detect is low in the following cycle.
- R2: When bit_valid is high at an edge, the new state is the accepted bit in the top stage (bit 3) with the previous bits 3..1 moved into bits 2..0. The old bit 0 is discarded.
- R3: When bit_valid is low at an edge, the state does not change, whatever the level on bit_in, and detect is low in the following cycle.
- R4: Detect is high in the cycle after an accepted bit exactly when the resulting state is 0010. That is, the last four accepted bits, oldest first, were 0, 1, 0, 0.
- R5: Detect is never high in two consecutive cycles, so each completed occurrence gives exactly one pulse.
- R6: Fewer than four bits accepted since reset never raise detect. This includes the stream 1, 0, 0.
- R7: Overlapping occurrences are each reported. The stream 0,1,0,0,1,0,0 gives two pulses, one after the fourth bit and one after the seventh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when bit_in carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | One-cycle pulse when the pattern has just completed |
| state_dbg | output | 4 | Stored bits; bit 3 is the newest |

## Verification
Every result is due one cycle after its stimulus. A bit driven with bit_valid high is taken at the next rising edge. Both the new state and the detect level it causes can be read during the cycle after that edge, and no later than the edge after it. The bench sets inputs on a falling edge and reads both outputs on the following falling edge, half a period after the rising edge that took the bit. Each comparison therefore covers exactly one register stage. Idle cycles are checked the same way: the state must not move and detect must stay low.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned SPD_LEN = 4;
  // Register image, top stage (newest bit) first: oldest-first stream 0,1,0,0
  localparam logic [SPD_LEN-1:0] SPD_MATCH = 4'b0010;
  // Start state of the minimal machine: holds no prefix of the pattern
  localparam logic [SPD_LEN-1:0] SPD_START = 4'b1100;
endpackage

// File: rtl/spd_stage.sv
module spd_stage #(
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_BIT;
    else if (en) q <= d;
  end
endmodule

// File: rtl/spd_match.sv
module spd_match #(
  parameter int unsigned     LEN     = 4,
  parameter logic [LEN-1:0]  PATTERN = '0
) (
  input  logic [LEN-1:0] state,
  input  logic           fresh,
  output logic           hit
);
  logic [LEN-1:0] eq;

  // Per-stage compare; the reduction below is the wide AND
  for (genvar i = 0; i < LEN; i++) begin : g_eq
    assign eq[i] = ~(state[i] ^ PATTERN[i]);
  end

  assign hit = fresh & (&eq);
endmodule

// File: rtl/serial_pattern_detect.sv
module serial_pattern_detect
  import spd_pkg::*;
#(
  parameter int unsigned    LEN       = SPD_LEN,
  parameter logic [LEN-1:0] PATTERN   = SPD_MATCH,
  parameter logic [LEN-1:0] RST_STATE = SPD_START
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_valid,
  input  logic           bit_in,
  output logic           detect,
  output logic [LEN-1:0] state_dbg
);
  localparam int unsigned TOP = LEN - 1;

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] stage_d;
  logic           fresh_q;

  // Newest bit enters the top stage; each stage takes the one above it
  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == TOP) begin : g_head
      assign stage_d[i] = bit_in;
    end else begin : g_body
      assign stage_d[i] = state_q[i+1];
    end
    spd_stage #(.RST_BIT(RST_STATE[i])) u_stage (
      .clk (clk),
      .rst (rst),
      .en  (bit_valid),
      .d   (stage_d[i]),
      .q   (state_q[i])
    );
  end

  // Marks a cycle whose state was produced by an accepted bit
  always_ff @(posedge clk) begin
    if (rst) fresh_q <= 1'b0;
    else     fresh_q <= bit_valid;
  end

  spd_match #(.LEN(LEN), .PATTERN(PATTERN)) u_match (
    .state (state_q),
    .fresh (fresh_q),
    .hit   (detect)
  );

  assign state_dbg = state_q;
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int unsigned    LEN     = 4,
  parameter logic [LEN-1:0] PATTERN = '0
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_valid,
  input logic           bit_in,
  input logic           detect,
  input logic [LEN-1:0] state_dbg
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] seen_q;
  logic          took_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      took_q <= 1'b0;
    end else begin
      took_q <= bit_valid;
      if (bit_valid && seen_q != CW'(LEN)) seen_q <= seen_q + 1'b1;
    end
  end

  a_r2_shift: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> state_dbg == {$past(bit_in), $past(state_dbg[LEN-1:1])});

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(state_dbg) && !detect));

  a_r4_only_on_match: assert property (@(posedge clk) disable iff (rst)
    detect |-> state_dbg == PATTERN);

  a_r4_hit: assert property (@(posedge clk) disable iff (rst)
    (took_q && state_dbg == PATTERN) |-> detect);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);

  a_r6_no_early: assert property (@(posedge clk) disable iff (rst)
    (seen_q < CW'(LEN)) |-> !detect);
endmodule

bind serial_pattern_detect spd_checker #(.LEN(LEN), .PATTERN(PATTERN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .detect    (detect),
  .state_dbg (state_dbg)
);

// File: tb/serial_pattern_detect_test.sv
module serial_pattern_detect_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       detect;
  logic [3:0] state_dbg;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model
  logic [3:0] exp_state;
  int         hist;
  int         accepted;
  logic       prev_det;
  int         pulses;

  serial_pattern_detect uut (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .detect    (detect),
    .state_dbg (state_dbg)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic do_reset();
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_state = 4'b1100; hist = 0; accepted = 0; prev_det = 1'b0;
    check("R1 state", state_dbg, 4'b1100);
    check("R1 detect", detect, 0);
  endtask

  task automatic step(input logic v, input logic b);
    logic want;
    bit_valid = v; bit_in = b;
    @(negedge clk);
    if (v) begin
      exp_state = {b, exp_state[3:1]};
      hist = ((hist << 1) | int'(b)) & 15;
      accepted++;
      want = (accepted >= 4) && (hist == 4'b0100);
      check("R2 state", state_dbg, exp_state);
      if (accepted < 4) check("R6 early", detect, 0);
      else              check("R4 detect", detect, want);
    end else begin
      check("R3 state held", state_dbg, exp_state);
      check("R3 detect idle", detect, 0);
    end
    if (prev_det) check("R5 single pulse", detect, 0);
    prev_det = detect;
    if (detect) pulses++;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R6: 1,0,0 right after reset must not flag
    do_reset();
    step(1, 1); step(1, 0); step(1, 0);
    check("R6 after 1,0,0", detect, 0);
    // R7: overlapping occurrences
    do_reset();
    pulses = 0;
    step(1, 0); step(1, 1); step(1, 0); step(1, 0);
    step(1, 1); step(1, 0); step(1, 0);
    check("R7 overlap pulses", pulses, 2);
    // exhaustive sweep of all 8-bit streams, with and without idle gaps
    for (int gap = 0; gap < 2; gap++) begin
      for (int s = 0; s < 256; s++) begin
        do_reset();
        for (int k = 7; k >= 0; k--) begin
          step(1, s[k]);
          if (gap != 0) step(0, ~s[k]);
        end
      end
    end
    // reset in mid-stream returns to the start state
    step(1, 0); step(1, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-stream state", state_dbg, 4'b1100);
    check("R1 mid-stream detect", detect, 0);
    rst = 1'b0;
    finish_run();
  end
endmodule